// File: doc/BRIEF.md
# Error record store port controller

This block gives a host a small byte-wide register window, sixteen ports deep, in front of a compact persistent store of error records. The host picks an operation kind, can set a byte offset into its log buffer, and names a memory word through which 64-bit record identifiers are passed back and forth. A write to the trigger port starts the selected operation, and the data of that write also supplies the log buffer base. A simple word-wide memory master lets the block fetch record headers, copy record bytes in either direction, and read or write identifier words.

The store keeps a fixed number of slots. Each slot holds an identifier, a byte length and up to a fixed number of data words. Identifiers are handed out in increasing order. A read of the iteration port walks the stored identifiers in slot order and writes the result back to the exchange word. The status port reports a busy flag and the completion code of the last operation.

Top module: `errlog_port_ctrl`

## Requirements
- R1: After reset the operation port reads 0, the status port reads 0x00 (idle, success), the record count reads 0, the offset reads 0, port 0x03 reads 0x00 and ports 0x0C to 0x0F read 0xFF.
- R2: Multi-byte ports are little-endian. Offset is at ports 0x04 to 0x07. A byte write changes only its own lane. Port 0x00 keeps bits 1:0 of the written byte as the operation code: 0 store, 1 fetch, 2 erase, 3 no-op.
- R3: Ports 0x08 to 0x0B read the number of valid records as a 32-bit little-endian value. Writes to them set the exchange-word address. The count never exceeds the number of slots.
- R4: A store operation reads the 32-bit byte length at base+offset+20. It copies ceil(length/4) words starting at base+offset into the first free slot, gives the record the next identifier (the first is 1), and reports status 0.
- R5: A store operation with length 0 reports status 3. One with a length above the slot capacity (32 bytes by default), or with every slot in use, reports status 1. In these cases the count stays the same.
- R6: A fetch operation reads the identifier from the exchange word (low word at the exchange address, high word at +4) and writes the record's words to base+offset with status 0. It reports 5 if the identifier is unknown and 4 if the store is empty, and writes no record data in either case.
- R7: An erase operation removes the record named by the exchange word and reports status 0, or 5 if that record is unknown, or 4 if the store is empty. The data of the trigger write has no effect on it.
- R8: A no-op operation makes no memory access and reports status 0.
- R9: A read of port 0x02 reads the exchange word. It writes back the identifier of the next valid slot after the named record, in slot order. If the named record is the last one or is unknown, it writes back the first valid identifier. If the store is empty it writes all ones and reports status 4; otherwise it reports status 0.
- R10: Status bit 7 is high while an operation moves data through memory. While it is high, port writes and iteration reads are ignored.
- R11: An operation starts only on a write to port 0x0C. The buffer base is formed from the last bytes written to 0x0F, 0x0E and 0x0D above the byte written to 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Port write strobe |
| io_rd | input | 1 | Port read strobe |
| io_addr | input | 4 | Port number |
| io_wdata | input | 8 | Port write byte |
| io_rdata | output | 8 | Port read byte (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word |
| mem_ack | input | 1 | Memory access complete |

## Verification
The bench goes after the iteration wrap. A design that forgets to wrap would write all ones or a stale identifier after the last record instead of the first one. It also tries unknown and empty identifiers on fetch and erase. A design that mixes up their order would report "not found" on an empty store, or would copy garbage out.

Store lengths of 0, 33 and exactly the capacity are applied, and a fifth store is issued into a full store. A wrong length decode or a missing full check would then corrupt the count. The bench writes the operation port in the middle of a transfer and also writes the base bytes without touching port 0x0C. A design that lacks the busy gate or that triggers on the wrong byte would change its operation or start one uninvited.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_FETCH = 2'd1,
    OP_ERASE = 2'd2,
    OP_NOP   = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_CPIN, S_IDLO, S_IDHI, S_DECIDE, S_CPOUT, S_WLO, S_WHI
  } seq_e;

  localparam logic [6:0] ST_OK       = 7'd0;
  localparam logic [6:0] ST_NOSPACE  = 7'd1;
  localparam logic [6:0] ST_FAILED   = 7'd3;
  localparam logic [6:0] ST_EMPTY    = 7'd4;
  localparam logic [6:0] ST_NOTFOUND = 7'd5;

  function automatic logic [31:0] words_of(input logic [31:0] nbytes);
    return (nbytes + 32'd3) >> 2;
  endfunction

  function automatic logic [31:0] put_lane(input logic [31:0] w, input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*lane +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/errlog_regs.sv
module errlog_regs
  import errlog_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [3:0]       io_addr,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic             busy,
  input  logic [6:0]       status,
  input  logic [CNT_W-1:0] count,
  output op_e              op,
  output logic [31:0]      offset,
  output logic [31:0]      exch_addr,
  output logic             trig,
  output logic [31:0]      trig_base,
  output logic             iter
);
  logic        wr_ok;
  logic [23:0] base_hi;
  logic [31:0] cnt32;

  assign wr_ok     = io_wr && !busy;
  assign trig      = wr_ok && (io_addr == 4'hC);
  assign trig_base = {base_hi, io_wdata};
  assign iter      = io_rd && !busy && (io_addr == 4'h2);
  assign cnt32     = 32'(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op        <= OP_STORE;
      offset    <= '0;
      exch_addr <= '0;
      base_hi   <= '0;
    end else if (wr_ok) begin
      case (io_addr[3:2])
        2'd0: if (io_addr[1:0] == 2'd0) op <= op_e'(io_wdata[1:0]);
        2'd1: offset <= put_lane(offset, io_addr[1:0], io_wdata);
        2'd2: exch_addr <= put_lane(exch_addr, io_addr[1:0], io_wdata);
        default: begin
          case (io_addr[1:0])
            2'd1:    base_hi[7:0]   <= io_wdata;
            2'd2:    base_hi[15:8]  <= io_wdata;
            2'd3:    base_hi[23:16] <= io_wdata;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    case (io_addr[3:2])
      2'd0: begin
        case (io_addr[1:0])
          2'd0:    io_rdata = {6'd0, op};
          2'd1:    io_rdata = {busy, status};
          default: io_rdata = 8'h00;
        endcase
      end
      2'd1:    io_rdata = offset[8*io_addr[1:0] +: 8];
      2'd2:    io_rdata = cnt32[8*io_addr[1:0] +: 8];
      default: io_rdata = 8'hFF;
    endcase
  end
endmodule

// File: rtl/errlog_store.sv
module errlog_store #(
  parameter int NSLOTS    = 4,
  parameter int REC_WORDS = 8,
  localparam int IDX_W    = (NSLOTS > 1) ? $clog2(NSLOTS) : 1,
  localparam int WORD_W   = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1,
  localparam int CNT_W    = $clog2(NSLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [31:0]       wr_data,
  input  logic              commit,
  input  logic [63:0]       commit_id,
  input  logic [31:0]       commit_len,
  input  logic              clr,
  input  logic [IDX_W-1:0]  clr_slot,
  input  logic [63:0]       key_id,
  input  logic [WORD_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_slot,
  output logic [31:0]       hit_len,
  output logic [63:0]       iter_id,
  output logic [IDX_W-1:0]  free_slot,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [NSLOTS-1:0] valid;
  logic [63:0]       ids  [NSLOTS];
  logic [31:0]       lens [NSLOTS];
  logic [31:0]       data [NSLOTS][REC_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
    end else begin
      if (commit) valid[wr_slot] <= 1'b1;
      if (clr)    valid[clr_slot] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data[wr_slot][wr_word] <= wr_data;
    if (commit) begin
      ids[wr_slot]  <= commit_id;
      lens[wr_slot] <= commit_len;
    end
  end

  assign rd_data = data[wr_slot][rd_word];
  assign hit_len = lens[hit_slot];

  always_comb begin
    logic got_first, got_next;
    logic [63:0] first_id, next_id;
    hit = 1'b0; hit_slot = '0; full = 1'b1; free_slot = '0; count = '0;
    got_first = 1'b0; got_next = 1'b0; first_id = '1; next_id = '1;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (!valid[i]) begin full = 1'b0; free_slot = IDX_W'(i); end
    end
    for (int i = 0; i < NSLOTS; i++) begin
      if (valid[i]) count = count + CNT_W'(1);
      if (valid[i] && ids[i] == key_id && !hit) begin hit = 1'b1; hit_slot = IDX_W'(i); end
      if (valid[i] && !got_first) begin got_first = 1'b1; first_id = ids[i]; end
    end
    for (int i = 0; i < NSLOTS; i++) begin
      if (hit && valid[i] && IDX_W'(i) > hit_slot && !got_next) begin
        got_next = 1'b1; next_id = ids[i];
      end
    end
    iter_id = got_next ? next_id : first_id;
  end
endmodule

// File: rtl/errlog_port_ctrl.sv
module errlog_port_ctrl
  import errlog_pkg::*;
#(
  parameter int          NSLOTS    = 4,
  parameter int          REC_WORDS = 8,
  parameter logic [63:0] ID_FIRST  = 64'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [3:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int          IDX_W     = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
  localparam int          WORD_W    = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;
  localparam int          WCNT_W    = $clog2(REC_WORDS + 1);
  localparam int          CNT_W     = $clog2(NSLOTS + 1);
  localparam logic [31:0] MAX_BYTES = 32'(REC_WORDS * 4);

  seq_e              st;
  op_e               op, cur_op;
  logic              is_iter, busy, trig, iter, xfer_done, last_word;
  logic [6:0]        status;
  logic [31:0]       offset, exch_addr, trig_base, eff_base, rec_len;
  logic [WCNT_W-1:0] wcnt, nwords;
  logic [IDX_W-1:0]  slot;
  logic [63:0]       id_lat, res_id, next_id;
  logic [31:0]       rd_data, hit_len;
  logic              hit, full, commit, clr;
  logic [IDX_W-1:0]  hit_slot, free_slot;
  logic [63:0]       iter_id;
  logic [CNT_W-1:0]  count;

  assign busy      = (st != S_IDLE);
  assign xfer_done = mem_req && mem_ack;
  assign last_word = (wcnt == nwords - WCNT_W'(1));
  assign commit    = (st == S_CPIN) && mem_ack && last_word;
  assign clr       = (st == S_DECIDE) && !is_iter && hit && (cur_op == OP_ERASE);

  errlog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .io_wr, .io_rd, .io_addr, .io_wdata, .io_rdata,
    .busy, .status, .count, .op, .offset, .exch_addr, .trig, .trig_base, .iter
  );

  errlog_store #(.NSLOTS(NSLOTS), .REC_WORDS(REC_WORDS)) u_store (
    .clk, .rst_n,
    .wr_en(st == S_CPIN && mem_ack), .wr_slot(slot), .wr_word(wcnt[WORD_W-1:0]),
    .wr_data(mem_rdata), .commit, .commit_id(next_id), .commit_len(rec_len),
    .clr, .clr_slot(hit_slot), .key_id(id_lat), .rd_word(wcnt[WORD_W-1:0]),
    .rd_data, .hit, .hit_slot, .hit_len, .iter_id, .free_slot, .full, .count
  );

  always_comb begin
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = exch_addr; mem_wdata = '0;
    case (st)
      S_HDR:   mem_addr = eff_base + 32'd20;
      S_CPIN:  mem_addr = eff_base + {wcnt, 2'b00};
      S_IDLO:  ;
      S_IDHI:  mem_addr = exch_addr + 32'd4;
      S_CPOUT: begin mem_we = 1'b1; mem_addr = eff_base + {wcnt, 2'b00}; mem_wdata = rd_data; end
      S_WLO:   begin mem_we = 1'b1; mem_wdata = res_id[31:0]; end
      S_WHI:   begin mem_we = 1'b1; mem_addr = exch_addr + 32'd4; mem_wdata = res_id[63:32]; end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cur_op <= OP_STORE; is_iter <= 1'b0; status <= ST_OK;
      eff_base <= '0; rec_len <= '0; wcnt <= '0; nwords <= '0; slot <= '0;
      id_lat <= '0; res_id <= '0; next_id <= ID_FIRST;
    end else begin
      case (st)
        S_IDLE: begin
          wcnt <= '0;
          if (trig) begin
            eff_base <= trig_base + offset; cur_op <= op; is_iter <= 1'b0;
            case (op)
              OP_NOP:   status <= ST_OK;
              OP_STORE: if (full) status <= ST_NOSPACE;
                        else begin slot <= free_slot; st <= S_HDR; end
              default:  if (count == '0) status <= ST_EMPTY;
                        else st <= S_IDLO;
            endcase
          end else if (iter) begin
            is_iter <= 1'b1;
            if (count == '0) begin res_id <= '1; st <= S_WLO; end
            else st <= S_IDLO;
          end
        end
        S_HDR: if (mem_ack) begin
          if (mem_rdata == '0) begin status <= ST_FAILED; st <= S_IDLE; end
          else if (mem_rdata > MAX_BYTES) begin status <= ST_NOSPACE; st <= S_IDLE; end
          else begin
            rec_len <= mem_rdata;
            nwords  <= WCNT_W'(words_of(mem_rdata));
            st      <= S_CPIN;
          end
        end
        S_CPIN: if (mem_ack) begin
          wcnt <= wcnt + WCNT_W'(1);
          if (last_word) begin status <= ST_OK; next_id <= next_id + 64'd1; st <= S_IDLE; end
        end
        S_IDLO: if (mem_ack) begin id_lat[31:0] <= mem_rdata; st <= S_IDHI; end
        S_IDHI: if (mem_ack) begin id_lat[63:32] <= mem_rdata; st <= S_DECIDE; end
        S_DECIDE: begin
          if (is_iter) begin res_id <= iter_id; st <= S_WLO; end
          else if (!hit) begin status <= ST_NOTFOUND; st <= S_IDLE; end
          else if (cur_op == OP_ERASE) begin status <= ST_OK; st <= S_IDLE; end
          else begin
            slot   <= hit_slot;
            nwords <= WCNT_W'(words_of(hit_len));
            wcnt   <= '0;
            st     <= S_CPOUT;
          end
        end
        S_CPOUT: if (mem_ack) begin
          wcnt <= wcnt + WCNT_W'(1);
          if (last_word) begin status <= ST_OK; st <= S_IDLE; end
        end
        S_WLO: if (mem_ack) st <= S_WHI;
        S_WHI: if (mem_ack) begin
          status <= (count == '0) ? ST_EMPTY : ST_OK;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/errlog_port_ctrl_chk.sv
module errlog_port_ctrl_chk #(
  parameter int NSLOTS = 4,
  parameter int CNT_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_req,
  input logic             xfer_done,
  input logic             io_wr,
  input logic             io_rd,
  input logic [3:0]       io_addr,
  input logic [7:0]       io_rdata,
  input logic [1:0]       op_q,
  input logic [CNT_W-1:0] count,
  input logic             trig,
  input logic             full
);
  p_mem_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_status_busy_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 4'h1) |-> (io_rdata[7] == busy));

  p_op_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && io_wr && io_addr == 4'h0) |=> (op_q == $past(op_q)));

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NSLOTS));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, count} <= {1'b0, $past(count)} + 1'b1) && ({1'b0, count} + 1'b1 >= {1'b0, $past(count)}));

  p_nop_stays_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && op_q == 2'd3) |=> !busy);

  p_store_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && op_q == 2'd0 && !full) |=> busy);

  p_xfer_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> busy);
endmodule

bind errlog_port_ctrl errlog_port_ctrl_chk #(.NSLOTS(NSLOTS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .xfer_done(xfer_done),
  .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_rdata(io_rdata),
  .op_q(op), .count(count), .trig(trig), .full(full)
);

// File: tb/errlog_port_ctrl_bench.sv
`timescale 1ns/1ps
module errlog_port_ctrl_bench;
  localparam int NS = 4, RW = 8, CAP = RW * 4;
  localparam logic [31:0] EXCH = 32'h80, RBUF = 32'h100, OBUF = 32'h200;

  logic clk = 0, rst_n = 0, io_wr = 0, io_rd = 0;
  logic [3:0] io_addr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [256];
  int nchk = 0, nfail = 0, nacc = 0;

  logic        mv   [NS];
  logic [63:0] mid  [NS];
  int          mlen [NS];
  logic [31:0] mdat [NS][RW];
  logic [63:0] m_next = 64'd1;
  logic [31:0] moff = 0;

  always #4 clk = ~clk;

  errlog_port_ctrl u_errlog_port_ctrl (
    .clk, .rst_n, .io_wr, .io_rd, .io_addr, .io_wdata, .io_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack
  );

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) begin
    if (mem_req) nacc <= nacc + 1;
    if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic iowr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic iord(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1; io_addr = a; #1 d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic wr32(input logic [3:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) iowr(a + 4'(i), v[8*i +: 8]);
  endtask

  task automatic rd32(input logic [3:0] a, output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin iord(a + 4'(i), b); v[8*i +: 8] = b; end
  endtask

  task automatic go(input logic [31:0] b);
    iowr(4'hF, b[31:24]); iowr(4'hE, b[23:16]); iowr(4'hD, b[15:8]); iowr(4'hC, b[7:0]);
  endtask

  task automatic wait_idle(output logic [7:0] s);
    int n = 0;
    do begin iord(4'h1, s); n++; end while (s[7] && n < 2000);
  endtask

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < NS; i++) if (mv[i]) c++;
    return c;
  endfunction

  function automatic int m_find(input logic [63:0] id);
    for (int i = 0; i < NS; i++) if (mv[i] && mid[i] == id) return i;
    return -1;
  endfunction

  function automatic logic [63:0] m_iter(input logic [63:0] id);
    int h = m_find(id);
    if (h >= 0) for (int i = h + 1; i < NS; i++) if (mv[i]) return mid[i];
    for (int i = 0; i < NS; i++) if (mv[i]) return mid[i];
    return '1;
  endfunction

  task automatic put_exch(input logic [63:0] id);
    mem[EXCH[9:2]] = id[31:0]; mem[EXCH[9:2] + 1] = id[63:32];
  endtask

  task automatic do_store(input int len);
    logic [7:0] s; logic [31:0] c; int exp_st, fs, w0;
    w0 = int'((RBUF + moff) >> 2);
    for (int w = 0; w < RW; w++) mem[w0 + w] = $urandom;
    mem[w0 + 5] = 32'(len);
    fs = -1;
    for (int i = NS - 1; i >= 0; i--) if (!mv[i]) fs = i;
    if (fs < 0) exp_st = 1; else if (len == 0) exp_st = 3; else if (len > CAP) exp_st = 1; else exp_st = 0;
    iowr(4'h0, 8'h00); go(RBUF); wait_idle(s);
    check(s == 8'(exp_st), exp_st == 0 ? "R4 store status" : "R5 store reject status", 64'(s), 64'(exp_st));
    if (exp_st == 0) begin
      mv[fs] = 1; mid[fs] = m_next; mlen[fs] = len; m_next++;
      for (int w = 0; w < RW; w++) mdat[fs][w] = mem[w0 + w];
    end
    rd32(4'h8, c);
    check(c == 32'(m_count()), "R3 record count after store", 64'(c), 64'(m_count()));
  endtask

  task automatic do_fetch(input logic [63:0] id);
    logic [7:0] s; int h, exp_st, w0; bit ok;
    w0 = int'((OBUF + moff) >> 2);
    for (int w = 0; w < RW; w++) mem[w0 + w] = 32'hDEAD_BEEF;
    put_exch(id); h = m_find(id);
    exp_st = (m_count() == 0) ? 4 : (h < 0) ? 5 : 0;
    iowr(4'h0, 8'h01); go(OBUF); wait_idle(s);
    check(s == 8'(exp_st), "R6 fetch status", 64'(s), 64'(exp_st));
    ok = 1;
    for (int w = 0; w < RW; w++) begin
      if (exp_st == 0 && w < (mlen[h] + 3) / 4) begin if (mem[w0 + w] != mdat[h][w]) ok = 0; end
      else if (mem[w0 + w] != 32'hDEAD_BEEF) ok = 0;
    end
    check(ok, "R6 fetched record words", 64'(mem[w0]), exp_st == 0 ? 64'(mdat[h][0]) : 64'hDEAD_BEEF);
  endtask

  task automatic do_erase(input logic [63:0] id);
    logic [7:0] s; logic [31:0] c; int h, exp_st;
    put_exch(id); h = m_find(id);
    exp_st = (m_count() == 0) ? 4 : (h < 0) ? 5 : 0;
    iowr(4'h0, 8'h02); go($urandom);
    wait_idle(s);
    check(s == 8'(exp_st), "R7 erase status", 64'(s), 64'(exp_st));
    if (exp_st == 0) mv[h] = 0;
    rd32(4'h8, c);
    check(c == 32'(m_count()), "R7 count after erase", 64'(c), 64'(m_count()));
  endtask

  task automatic do_iter(input logic [63:0] id);
    logic [7:0] s, d; logic [63:0] got, exp; int exp_st;
    put_exch(id); exp = m_iter(id); exp_st = (m_count() == 0) ? 4 : 0;
    iord(4'h2, d); wait_idle(s);
    got = {mem[EXCH[9:2] + 1], mem[EXCH[9:2]]};
    check(got == exp, "R9 iteration id", got, exp);
    check(s == 8'(exp_st), "R9 iteration status", 64'(s), 64'(exp_st));
  endtask

  function automatic logic [63:0] pick_id();
    int k = $urandom_range(0, NS);
    if (k < NS && mv[k]) return mid[k];
    return 64'h0000_00AB_0000_1234;
  endfunction

  initial begin
    logic [7:0] b, s; logic [31:0] v; int a0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) begin mv[i] = 0; mid[i] = 0; mlen[i] = 0; end
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk); rst_n = 1;

    iord(4'h0, b); check(b == 8'h00, "R1 op after reset", 64'(b), 0);
    iord(4'h1, b); check(b == 8'h00, "R1 status after reset", 64'(b), 0);
    iord(4'h3, b); check(b == 8'h00, "R1 unused port", 64'(b), 0);
    rd32(4'h4, v); check(v == 0, "R1 offset after reset", 64'(v), 0);
    rd32(4'h8, v); check(v == 0, "R1 count after reset", 64'(v), 0);
    rd32(4'hC, v); check(v == 32'hFFFF_FFFF, "R1 trigger ports read", 64'(v), 64'hFFFF_FFFF);

    wr32(4'h4, 32'h1234_5678); iowr(4'h6, 8'hAB); rd32(4'h4, v);
    check(v == 32'h12AB_5678, "R2 offset byte lanes", 64'(v), 64'h12AB_5678);
    wr32(4'h4, 32'h0); iowr(4'h0, 8'hFE); iord(4'h0, b);
    check(b == 8'h02, "R2 op keeps low bits", 64'(b), 2);
    wr32(4'h8, EXCH);

    do_iter(64'h5); do_fetch(64'h1); do_erase(64'h1);
    a0 = nacc; iowr(4'h0, 8'h03); go(RBUF); wait_idle(s);
    check(s == 0 && nacc == a0, "R8 no-op status and no access", 64'(nacc - a0), 0);
    a0 = nacc; iowr(4'h0, 8'h00); iowr(4'hF, 8'h0); iowr(4'hE, 8'h0); iowr(4'hD, 8'h1);
    iord(4'h1, s); rd32(4'h8, v);
    check(s == 0 && v == 0 && nacc == a0, "R11 no start without port 0x0C", 64'(nacc - a0), 0);

    do_store(0); do_store(CAP + 1); do_store(CAP); do_store(24);
    moff = 32'h40; wr32(4'h4, moff); do_store(7); do_fetch(mid[2]);
    moff = 0; wr32(4'h4, 0);
    do_fetch(mid[0]); do_fetch(64'hFFFF); do_store(13); do_store(9);
    do_iter(mid[0]); do_iter(mid[3]); do_iter(64'h77);

    iowr(4'h0, 8'h01); put_exch(mid[1]); go(OBUF);
    iord(4'h1, s); check(s[7] == 1'b1, "R10 busy during transfer", 64'(s), 64'h80);
    iowr(4'h0, 8'h02); wait_idle(s); iord(4'h0, b);
    check(b == 8'h01, "R10 op write ignored while busy", 64'(b), 1);

    do_erase(mid[1]); do_iter(mid[0]);
    for (int n = 0; n < 60; n++) begin
      case ($urandom_range(0, 3))
        0: do_store($urandom_range(0, CAP + 4));
        1: do_fetch(pick_id());
        2: do_erase(pick_id());
        default: do_iter(pick_id());
      endcase
    end
    for (int i = 0; i < NS; i++) if (mv[i]) do_erase(mid[i]);
    do_iter(64'h1);
    summary();
  end
endmodule